// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This controller sits on the host side of a flash interface and works out whether a program or erase operation has finished. A start pulse launches it. It then asks for status words over a simple request/acknowledge read port and compares the toggle bit (bit 6) between back-to-back reads. It also watches the exceeded-time bit (bit 5) of each word. If the toggle bit stops changing, it reports success. If the toggle bit is still changing after the time bit has risen, it reports failure and raises a one-cycle request for the reset command to be written.

The toggle bit can stop changing in the same cycle that the time bit rises. For that reason, a toggling pair that shows bit 5 high does not cause an immediate failure. The controller first runs a second, confirming pair of reads. The host sets a ceiling on the number of inconclusive rounds, and it can abandon an attempt at any time with an abort input. A new start always begins with a fresh pair of reads.

Top module: `tgl_poll_ctrl`

## Requirements
- R1: After reset, `status` is 2'b00 (idle), and `rd_req` and `rst_cmd` are low.
- R2: A `start` pulse given while `status` is not 2'b01 moves `status` to 2'b01 (busy) and raises `rd_req` on the next cycle. A `start` given while busy has no effect on the read sequence.
- R3: `rd_req` stays high, and `status` stays busy, until the controller reaches a decision. Every cycle in which both `rd_req` and `rd_ack` are high completes one read, and `rd_data` is sampled in that cycle.
- R4: A decision never comes from a single read. The first read of a pair stores bit 6 and the second read compares bit 6 against it. If the two values are equal, `status` becomes 2'b10 (done-ok) and `rst_cmd` stays low.
- R5: If a pair toggles and bit 5 of the second read is 0, a new pair starts. The first read of the new pair is stored and is not compared with any earlier read.
- R6: If a pair toggles and bit 5 of the second read is 1, one confirming pair follows. If that pair shows equal values in bit 6, the result is done-ok.
- R7: If the confirming pair toggles, `status` becomes 2'b11 (failed) and `rst_cmd` is high for exactly that first failed cycle.
- R8: `poll_limit` is sampled at start. When the number of toggling pairs with bit 5 low reaches `poll_limit`, the result is failed with `rst_cmd`. A limit of 0 acts as 1.
- R9: `abort` while busy returns `status` to idle on the next cycle with `rd_req` low and no `rst_cmd`. The abort takes priority over a read completing in the same cycle.
- R10: A done-ok or failed status is held until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a polling attempt |
| abort | input | 1 | Abandon the current attempt |
| poll_limit | input | CW (8) | Ceiling on inconclusive rounds, sampled at start |
| rd_req | output | 1 | Status read request |
| rd_ack | input | 1 | Read complete; `rd_data` valid |
| rd_data | input | DW (8) | Status word returned by the read |
| status | output | 2 | 00 idle, 01 busy, 10 done-ok, 11 failed |
| rst_cmd | output | 1 | One-cycle request to write the reset command |

## Verification
The bench applies these status-word patterns:
- Equal bit 6 on the first pair.
- A toggling pair with bit 5 low, followed by a steady pair. This shows that the second pair starts fresh and is not chained to the old read.
- A toggling pair with bit 5 high, followed by either a steady or a toggling confirming pair. This separates late success from true failure.
- Long runs of toggling that hit the round ceiling, including a ceiling of 0.

An abort after a single read, followed by a restart, shows that the stored toggle value is not carried over. A start pulse in the middle of a pair shows that a start given while busy is ignored.

// File: rtl/tgl_poll_pkg.sv
package tgl_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD1, ST_RD2, ST_RC1, ST_RC2, ST_OK, ST_FAIL
    } poll_state_e;

    localparam logic [1:0] PS_IDLE = 2'b00;
    localparam logic [1:0] PS_BUSY = 2'b01;
    localparam logic [1:0] PS_OK   = 2'b10;
    localparam logic [1:0] PS_FAIL = 2'b11;

    typedef struct packed {
        poll_state_e state;
        logic        rst_cmd;
    } poll_regs_t;
endpackage

// File: rtl/tgl_sample_cmp.sv
module tgl_sample_cmp #(
    parameter int DW      = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] rd_data,
    output logic          toggled,
    output logic          tmo
);
    logic first_d, first_q;

    always_comb begin
        first_d = first_q;
        if (capture) first_d = rd_data[TOG_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= first_d;
    end

    assign toggled = rd_data[TOG_BIT] ^ first_q;
    assign tmo     = rd_data[TMO_BIT];
endmodule

// File: rtl/tgl_round_cnt.sv
module tgl_round_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q, lim_d, lim_q;
    logic [CW:0]   nxt;

    always_comb begin
        nxt   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        last  = nxt >= {1'b0, lim_q};
        cnt_d = cnt_q;
        lim_d = lim_q;
        if (clr) begin
            cnt_d = '0;
            lim_d = limit;
        end else if (inc && !last) begin
            cnt_d = nxt[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end
endmodule

// File: rtl/tgl_poll_ctrl.sv
module tgl_poll_ctrl
    import tgl_poll_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CW      = 8,
    parameter int TOG_BIT = 6,
    parameter int TMO_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [CW-1:0] poll_limit,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic [1:0]    status,
    output logic          rst_cmd
);
    poll_regs_t r_d, r_q;
    logic busy, rd_done, capture, toggled, tmo;
    logic cnt_clr, cnt_inc, cnt_last;

    assign busy    = (r_q.state == ST_RD1) || (r_q.state == ST_RD2) ||
                     (r_q.state == ST_RC1) || (r_q.state == ST_RC2);
    assign rd_done = busy && rd_ack && !abort;
    assign capture = rd_done && ((r_q.state == ST_RD1) || (r_q.state == ST_RC1));

    tgl_sample_cmp #(.DW(DW), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT)) u_cmp (
        .clk(clk), .rst_n(rst_n), .capture(capture), .rd_data(rd_data),
        .toggled(toggled), .tmo(tmo)
    );

    tgl_round_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .limit(poll_limit), .last(cnt_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rst_cmd = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        if (!busy) begin
            if (start) begin
                r_d.state = ST_RD1;
                cnt_clr   = 1'b1;
            end
        end else if (abort) begin
            r_d.state = ST_IDLE;
        end else if (rd_done) begin
            unique case (r_q.state)
                ST_RD1: r_d.state = ST_RD2;
                ST_RC1: r_d.state = ST_RC2;
                ST_RD2: begin
                    if (!toggled)  r_d.state = ST_OK;
                    else if (tmo)  r_d.state = ST_RC1;
                    else if (cnt_last) begin
                        r_d.state   = ST_FAIL;
                        r_d.rst_cmd = 1'b1;
                    end else begin
                        r_d.state = ST_RD1;
                        cnt_inc   = 1'b1;
                    end
                end
                ST_RC2: begin
                    if (!toggled) r_d.state = ST_OK;
                    else begin
                        r_d.state   = ST_FAIL;
                        r_d.rst_cmd = 1'b1;
                    end
                end
                default: r_d.state = r_q.state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.rst_cmd <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_OK:   status = PS_OK;
            ST_FAIL: status = PS_FAIL;
            ST_IDLE: status = PS_IDLE;
            default: status = PS_BUSY;
        endcase
    end

    assign rd_req  = busy;
    assign rst_cmd = r_q.rst_cmd;
endmodule

// File: rtl/tgl_poll_ctrl_chk.sv
module tgl_poll_ctrl_chk
    import tgl_poll_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       abort,
    input logic       rd_req,
    input logic       rd_ack,
    input logic [1:0] status,
    input logic       rst_cmd
);
    assert_req_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> status == PS_BUSY);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !abort) |=> rd_req);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && status != PS_BUSY) |=> (status == PS_BUSY && rd_req));

    assert_fail_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |-> status == PS_FAIL);

    assert_cmd_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> !rst_cmd);

    assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && status == PS_BUSY) |=> (status == PS_IDLE && !rst_cmd));

    assert_hold_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == PS_OK || status == PS_FAIL) && !start) |=> $stable(status));
endmodule

bind tgl_poll_ctrl tgl_poll_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .rd_req(rd_req),
    .rd_ack(rd_ack), .status(status), .rst_cmd(rst_cmd)
);

// File: tb/tgl_poll_ctrl_test.sv
module tgl_poll_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       abort = 1'b0;
    logic [7:0] poll_limit = 8'd4;
    logic       rd_req;
    logic       rd_ack = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [1:0] status;
    logic       rst_cmd;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tgl_poll_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .poll_limit(poll_limit), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .status(status), .rst_cmd(rst_cmd)
    );

    function automatic logic [7:0] word(input logic t, input logic f);
        return {1'b0, t, f, 5'b0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic begin_op(input logic [7:0] lim);
        @(negedge clk);
        start = 1'b1;
        poll_limit = lim;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] d);
        @(negedge clk);
        rd_data = d;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "status", {6'b0, status}, 8'h00);
        chk("R1", "rd_req", {7'b0, rd_req}, 8'h00);
        chk("R1", "rst_cmd", {7'b0, rst_cmd}, 8'h00);
    endtask

    task automatic t_first_pair_ok;
        begin_op(8'd4);
        chk("R2", "busy after start", {6'b0, status}, 8'h01);
        chk("R2", "req after start", {7'b0, rd_req}, 8'h01);
        do_read(word(1'b0, 1'b0));
        chk("R4", "no decision on one read", {6'b0, status}, 8'h01);
        chk("R3", "req held", {7'b0, rd_req}, 8'h01);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do_read(word(1'b0, 1'b0));
        chk("R2", "start ignored while busy, ok", {6'b0, status}, 8'h02);
        chk("R4", "req dropped", {7'b0, rd_req}, 8'h00);
        chk("R4", "no rst_cmd", {7'b0, rst_cmd}, 8'h00);
    endtask

    task automatic t_fresh_pair;
        begin_op(8'd4);
        do_read(word(1'b0, 1'b0));
        do_read(word(1'b1, 1'b0));
        chk("R5", "busy after toggle", {6'b0, status}, 8'h01);
        do_read(word(1'b1, 1'b0));
        chk("R5", "busy after first of new pair", {6'b0, status}, 8'h01);
        do_read(word(1'b1, 1'b0));
        chk("R5", "ok on steady new pair", {6'b0, status}, 8'h02);
    endtask

    task automatic t_recheck_ok;
        begin_op(8'd1);
        do_read(word(1'b0, 1'b0));
        do_read(word(1'b1, 1'b1));
        chk("R6", "busy into recheck", {6'b0, status}, 8'h01);
        do_read(word(1'b1, 1'b1));
        do_read(word(1'b1, 1'b1));
        chk("R6", "recheck steady ok", {6'b0, status}, 8'h02);
        chk("R6", "no rst_cmd", {7'b0, rst_cmd}, 8'h00);
    endtask

    task automatic t_recheck_fail;
        begin_op(8'd4);
        do_read(word(1'b0, 1'b0));
        do_read(word(1'b1, 1'b1));
        do_read(word(1'b0, 1'b1));
        do_read(word(1'b1, 1'b1));
        chk("R7", "failed", {6'b0, status}, 8'h03);
        chk("R7", "rst_cmd pulse", {7'b0, rst_cmd}, 8'h01);
        @(negedge clk);
        chk("R7", "rst_cmd one cycle", {7'b0, rst_cmd}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R10", "failed held", {6'b0, status}, 8'h03);
    endtask

    task automatic t_limit;
        begin_op(8'd2);
        do_read(word(1'b0, 1'b0));
        do_read(word(1'b1, 1'b0));
        chk("R8", "busy after round 1", {6'b0, status}, 8'h01);
        do_read(word(1'b0, 1'b0));
        do_read(word(1'b1, 1'b0));
        chk("R8", "failed at limit 2", {6'b0, status}, 8'h03);
        chk("R8", "rst_cmd at limit", {7'b0, rst_cmd}, 8'h01);
        begin_op(8'd0);
        do_read(word(1'b1, 1'b0));
        do_read(word(1'b0, 1'b0));
        chk("R8", "limit 0 fails first round", {6'b0, status}, 8'h03);
        chk("R8", "rst_cmd limit 0", {7'b0, rst_cmd}, 8'h01);
    endtask

    task automatic t_abort;
        begin_op(8'd4);
        do_read(word(1'b0, 1'b0));
        @(negedge clk);
        abort = 1'b1;
        rd_ack = 1'b1;
        rd_data = word(1'b1, 1'b1);
        @(negedge clk);
        abort = 1'b0;
        rd_ack = 1'b0;
        chk("R9", "idle after abort", {6'b0, status}, 8'h00);
        chk("R9", "req low after abort", {7'b0, rd_req}, 8'h00);
        chk("R9", "no rst_cmd on abort", {7'b0, rst_cmd}, 8'h00);
        begin_op(8'd4);
        do_read(word(1'b1, 1'b0));
        chk("R9", "restart needs two reads", {6'b0, status}, 8'h01);
        do_read(word(1'b1, 1'b0));
        chk("R9", "restart pair ok", {6'b0, status}, 8'h02);
        repeat (4) @(negedge clk);
        chk("R10", "ok held", {6'b0, status}, 8'h02);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_pair_ok();
        t_fresh_pair();
        t_recheck_ok();
        t_recheck_fail();
        t_limit();
        t_abort();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule